// File: doc/BRIEF.md
# Parameterized Set-Associative Cache Controller

This block is a single-level cache placed between a simple processor load/store port and a slower backing memory. Both sides use request/acknowledge handshakes. The processor holds `cpu_req` and its address, write flag and write data steady until `cpu_ready` pulses for one cycle. For a load, `cpu_rdata` is valid in that same cycle. The memory side raises `mem_req` and keeps it raised until `mem_ack` pulses.

The storage is `NUM_SETS` sets of `NUM_WAYS` ways, and each line holds one data word. A single set of RTL therefore covers three organizations:
- direct-mapped, with one way;
- set-associative;
- fully-associative, with one set.

The low address bits pick the set and the remaining bits are kept as the tag. Every way of the selected set is compared in parallel. On a miss the controller fills a free way first. Only when the set is full does it take a victim from a per-set replacement block.

The parameter `WRITE_BACK` selects the write policy:
- **Write-through (0):** every store is forwarded to memory.
- **Write-back (1):** stores stay in the cache, and a modified line is written out only when it is evicted.

Both policies allocate a line on a write miss.

Top module: `cache_assoc`

## Requirements
- R1: The set index is `addr & (NUM_SETS-1)` and the tag is the remaining upper address bits. With 4 sets, addresses 0x0, 0x4 and 0x8 all use set 0, and up to `NUM_WAYS` such lines stay resident together.
- R2: After reset the cache is empty. `cpu_ready` and `mem_req` are low, and the first access to every address misses.
- R3: A hit raises `cpu_ready` in the cycle after the request is accepted. A hit makes no memory request, and a load hit returns the stored word.
- R4: A miss issues one memory read of the requested address and holds `cpu_ready` low until `mem_ack`. A load miss returns the memory word, and the line is installed so that the next access to it hits.
- R5: While the selected set has an invalid way, a miss fills that way and evicts nothing.
- R6: A miss to a full set evicts lines in the order they were filled, using a per-set round-robin pointer that starts at way 0.
- R7: With one way, an address that maps to an occupied set replaces the previous occupant, so the old address misses again.
- R8: With one set, any `NUM_WAYS` distinct addresses are resident together regardless of their low bits.
- R9: In write-through mode, every store writes its address and data to memory (`mem_we`=1) and also updates the cache. `cpu_ready` follows that write's `mem_ack`.
- R10: In write-back mode, a store hit updates only the cache. Memory is not touched and the store completes in one cycle.
- R11: In write-back mode, evicting a modified line first writes the old tag, index and data to memory, then refills. `cpu_ready` waits for both acknowledges, and the stored value is later read back from memory intact.
- R12: A write miss refills and allocates the line in both modes. In write-through mode the allocated line is clean, so evicting it causes no memory write.
- R13: Once raised, `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` stay stable until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Processor request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Store data |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Load data, valid while `cpu_ready` is high |
| mem_req | output | 1 | Memory request, held until `mem_ack` |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_ack | input | 1 | One-cycle memory acknowledge |
| mem_rdata | input | DATA_W | Memory read data, valid with `mem_ack` |

## Verification
The bench sweeps every address of a 4-set, 4-way write-back instance. It first fills each set through its free ways, then evicts every modified line. A design that evicted before using a free way, or that rotated victims out of fill order, would show an eviction latency or a written-back address the bench does not expect. A write-back design that leaked store hits to memory, or that lost a modified line on eviction, would show memory writes during hits or stale data on re-read.

A direct-mapped write-through instance is driven with conflicting addresses and write misses. A dirty flag wrongly set on an allocated line would show up there as an extra memory write. A fully-associative instance is filled with addresses whose low bits differ. An index taken from those bits would make one of them miss.

// File: rtl/cache_assoc_pkg.sv
// Package: shared controller state encoding for the cache.
package cache_assoc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,  // waiting for a processor request
        ST_EVICT = 3'd1,  // writing a modified victim to memory
        ST_FILL  = 3'd2,  // reading the missed line from memory
        ST_WTHRU = 3'd3,  // forwarding a store to memory
        ST_RESP  = 3'd4   // one-cycle completion to the processor
    } ctl_state_t;

endpackage

// File: rtl/cache_way_bank.sv
// Module: one way of storage across all sets.
// Holds valid, dirty, tag and data per set. Reads are combinational at
// rd_set; a write installs a valid line at wr_set.
// Assumes a synchronous active-low reset clears valid and dirty only.
module cache_way_bank #(
    parameter int NUM_SETS = 4,
    parameter int SET_W    = 2,
    parameter int TAG_W    = 6,
    parameter int DATA_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SET_W-1:0]  rd_set,
    input  logic              wr_en,
    input  logic [SET_W-1:0]  wr_set,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_dirty,
    output logic              rd_valid,
    output logic              rd_dirty,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [DATA_W-1:0] rd_data
);

    logic [NUM_SETS-1:0] valid_r;
    logic [NUM_SETS-1:0] dirty_r;
    logic [TAG_W-1:0]    tag_r  [NUM_SETS];
    logic [DATA_W-1:0]   data_r [NUM_SETS];

    // Status bits: cleared by reset, set by a line install.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_r <= '0;
            dirty_r <= '0;
        end else if (wr_en) begin
            valid_r[wr_set] <= 1'b1;
            dirty_r[wr_set] <= wr_dirty;
        end
    end

    // Tag and data payload: written on install, not reset.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_r[wr_set]  <= wr_tag;
            data_r[wr_set] <= wr_data;
        end
    end

    // Read port: combinational view of the addressed set.
    always_comb begin
        rd_valid = valid_r[rd_set];
        rd_dirty = dirty_r[rd_set];
        rd_tag   = tag_r[rd_set];
        rd_data  = data_r[rd_set];
    end

endmodule

// File: rtl/cache_match.sv
// Module: tag comparison and free-way search across the ways of one set.
// Reports a hit and its way, and the lowest-numbered invalid way.
// Assumes at most one valid way carries a given tag.
module cache_match #(
    parameter int NUM_WAYS = 2,
    parameter int WAY_W    = 1,
    parameter int TAG_W    = 6
) (
    input  logic [NUM_WAYS-1:0]            way_valid,
    input  logic [NUM_WAYS-1:0][TAG_W-1:0] way_tag,
    input  logic [TAG_W-1:0]               lookup_tag,
    output logic                           hit,
    output logic [WAY_W-1:0]               hit_way,
    output logic                           has_free,
    output logic [WAY_W-1:0]               free_way
);

    // Priority scan from high to low, so the lowest matching way wins.
    always_comb begin
        hit      = 1'b0;
        hit_way  = '0;
        has_free = 1'b0;
        free_way = '0;
        for (int w = NUM_WAYS - 1; w >= 0; w--) begin
            if (way_valid[w] && (way_tag[w] == lookup_tag)) begin
                hit     = 1'b1;
                hit_way = WAY_W'(w);
            end
            if (!way_valid[w]) begin
                has_free = 1'b1;
                free_way = WAY_W'(w);
            end
        end
    end

endmodule

// File: rtl/cache_victim.sv
// Module: per-set round-robin victim selection.
// Each set keeps a pointer, starting at way 0, that advances after it is
// used for an eviction. Assumes advance is raised only for a full set.
module cache_victim #(
    parameter int NUM_SETS = 4,
    parameter int SET_W    = 2,
    parameter int NUM_WAYS = 2,
    parameter int WAY_W    = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SET_W-1:0] set_idx,
    input  logic             advance,
    output logic [WAY_W-1:0] victim_way
);

    logic [WAY_W-1:0] ptr_r [NUM_SETS];

    // Pointer update: reset to way 0, wrap after the last way.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < NUM_SETS; s++) ptr_r[s] <= '0;
        end else if (advance) begin
            if (ptr_r[set_idx] == WAY_W'(NUM_WAYS - 1)) ptr_r[set_idx] <= '0;
            else ptr_r[set_idx] <= ptr_r[set_idx] + 1'b1;
        end
    end

    // Victim output: pointer of the addressed set.
    assign victim_way = ptr_r[set_idx];

endmodule

// File: rtl/cache_assoc.sv
// Module: set-associative cache controller (top).
// Sits between a processor load/store handshake and a memory handshake.
// One-word lines; NUM_WAYS=1 gives direct-mapped, NUM_SETS=1 gives fully
// associative. WRITE_BACK selects write-back (1) or write-through (0).
// Assumes the processor holds its request fields until cpu_ready and the
// memory acknowledges with a single-cycle mem_ack. NUM_SETS is a power of 2.
module cache_assoc
    import cache_assoc_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 16,
    parameter int NUM_SETS   = 4,
    parameter int NUM_WAYS   = 2,
    parameter int WRITE_BACK = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);

    localparam int IDX_W = $clog2(NUM_SETS);
    localparam int SET_W = (IDX_W > 0) ? IDX_W : 1;
    localparam int WAY_W = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1;
    localparam int TAG_W = ADDR_W - IDX_W;
    localparam bit WB    = (WRITE_BACK != 0);

    ctl_state_t        state_r;
    logic [ADDR_W-1:0] addr_q;
    logic              we_q;
    logic [DATA_W-1:0] wdata_q;
    logic [WAY_W-1:0]  way_q;
    logic [TAG_W-1:0]  evict_tag_q;
    logic [DATA_W-1:0] evict_data_q;
    logic [DATA_W-1:0] rdata_q;

    logic [SET_W-1:0]  req_set, q_set;
    logic [TAG_W-1:0]  req_tag, q_tag;
    logic [ADDR_W-1:0] evict_addr;

    logic [NUM_WAYS-1:0]             way_valid, way_dirty;
    logic [NUM_WAYS-1:0][TAG_W-1:0]  way_tag;
    logic [NUM_WAYS-1:0][DATA_W-1:0] way_data;

    logic             hit, has_free;
    logic [WAY_W-1:0] hit_way, free_way, victim_way;
    logic             accept, repl_adv;

    logic              bank_we;
    logic [WAY_W-1:0]  bank_way;
    logic [SET_W-1:0]  bank_set;
    logic [TAG_W-1:0]  bank_tag;
    logic [DATA_W-1:0] bank_data;
    logic              bank_dirty;

    // Address split: the set comes from the low bits, the tag is the rest.
    generate
        if (IDX_W > 0) begin : g_idx
            assign req_set    = cpu_addr[IDX_W-1:0];
            assign q_set      = addr_q[IDX_W-1:0];
            assign evict_addr = {evict_tag_q, q_set};
        end else begin : g_noidx
            assign req_set    = '0;
            assign q_set      = '0;
            assign evict_addr = evict_tag_q;
        end
    endgenerate
    assign req_tag = cpu_addr[ADDR_W-1:IDX_W];
    assign q_tag   = addr_q[ADDR_W-1:IDX_W];

    // Storage: one bank per way, all read at the requested set.
    generate
        for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
            cache_way_bank #(
                .NUM_SETS(NUM_SETS), .SET_W(SET_W),
                .TAG_W(TAG_W), .DATA_W(DATA_W)
            ) u_bank (
                .clk      (clk),
                .rst_n    (rst_n),
                .rd_set   (req_set),
                .wr_en    (bank_we && (bank_way == WAY_W'(w))),
                .wr_set   (bank_set),
                .wr_tag   (bank_tag),
                .wr_data  (bank_data),
                .wr_dirty (bank_dirty),
                .rd_valid (way_valid[w]),
                .rd_dirty (way_dirty[w]),
                .rd_tag   (way_tag[w]),
                .rd_data  (way_data[w])
            );
        end
    endgenerate

    cache_match #(
        .NUM_WAYS(NUM_WAYS), .WAY_W(WAY_W), .TAG_W(TAG_W)
    ) u_match (
        .way_valid  (way_valid),
        .way_tag    (way_tag),
        .lookup_tag (req_tag),
        .hit        (hit),
        .hit_way    (hit_way),
        .has_free   (has_free),
        .free_way   (free_way)
    );

    cache_victim #(
        .NUM_SETS(NUM_SETS), .SET_W(SET_W),
        .NUM_WAYS(NUM_WAYS), .WAY_W(WAY_W)
    ) u_victim (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_idx    (req_set),
        .advance    (repl_adv),
        .victim_way (victim_way)
    );

    assign accept   = (state_r == ST_IDLE) && cpu_req;
    assign repl_adv = accept && !hit && !has_free;

    // Bank write mux: a store hit in idle, or a line install when the refill is acknowledged.
    always_comb begin
        bank_we    = 1'b0;
        bank_way   = hit_way;
        bank_set   = req_set;
        bank_tag   = req_tag;
        bank_data  = cpu_wdata;
        bank_dirty = WB;
        if (accept && hit && cpu_we) begin
            bank_we = 1'b1;
        end else if ((state_r == ST_FILL) && mem_ack) begin
            bank_we    = 1'b1;
            bank_way   = way_q;
            bank_set   = q_set;
            bank_tag   = q_tag;
            bank_data  = we_q ? wdata_q : mem_rdata;
            bank_dirty = we_q && WB;
        end
    end

    // Controller sequence: lookup, optional writeback, refill, store forward, respond.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_r      <= ST_IDLE;
            addr_q       <= '0;
            we_q         <= 1'b0;
            wdata_q      <= '0;
            way_q        <= '0;
            evict_tag_q  <= '0;
            evict_data_q <= '0;
            rdata_q      <= '0;
        end else begin
            case (state_r)
                ST_IDLE: begin
                    if (cpu_req) begin
                        addr_q  <= cpu_addr;
                        we_q    <= cpu_we;
                        wdata_q <= cpu_wdata;
                        if (hit) begin
                            rdata_q <= cpu_we ? cpu_wdata : way_data[hit_way];
                            state_r <= (cpu_we && !WB) ? ST_WTHRU : ST_RESP;
                        end else begin
                            way_q        <= has_free ? free_way : victim_way;
                            evict_tag_q  <= way_tag[victim_way];
                            evict_data_q <= way_data[victim_way];
                            state_r      <= (WB && !has_free && way_dirty[victim_way])
                                            ? ST_EVICT : ST_FILL;
                        end
                    end
                end
                ST_EVICT: if (mem_ack) state_r <= ST_FILL;
                ST_FILL: begin
                    if (mem_ack) begin
                        rdata_q <= we_q ? wdata_q : mem_rdata;
                        state_r <= (we_q && !WB) ? ST_WTHRU : ST_RESP;
                    end
                end
                ST_WTHRU: if (mem_ack) state_r <= ST_RESP;
                ST_RESP:  state_r <= ST_IDLE;
                default:  state_r <= ST_IDLE;
            endcase
        end
    end

    // Port drive: memory request fields depend only on the registered state.
    always_comb begin
        cpu_ready = (state_r == ST_RESP);
        cpu_rdata = rdata_q;
        mem_req   = (state_r == ST_EVICT) || (state_r == ST_FILL) || (state_r == ST_WTHRU);
        mem_we    = (state_r == ST_EVICT) || (state_r == ST_WTHRU);
        mem_addr  = (state_r == ST_EVICT) ? evict_addr : addr_q;
        mem_wdata = (state_r == ST_EVICT) ? evict_data_q : wdata_q;
    end

endmodule

// File: rtl/cache_assoc_chk.sv
// Module: protocol and policy checker for cache_assoc, bound to every instance.
// Assumes the processor keeps its request fields stable until cpu_ready.
module cache_assoc_chk #(
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 16,
    parameter int WRITE_BACK = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_req,
    input logic              cpu_we,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic [DATA_W-1:0] cpu_wdata,
    input logic              cpu_ready,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              mem_ack
);

    // R2: no activity in the first cycle after reset
    a_r2_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!cpu_ready && !mem_req));

    // R13: memory request fields hold until acknowledged
    a_r13_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) &&
                                   $stable(mem_we) && $stable(mem_wdata)));

    // R3: completion is a single-cycle pulse
    a_r3_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |=> !cpu_ready);

    // R4: no completion while a memory transfer is still unacknowledged
    a_r4_wait_for_ack: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mem_req) && !$past(mem_ack)) |-> !cpu_ready);

    // R11: in write-back mode, a writeback is always followed by a refill read
    a_r11_refill_after_writeback: assert property (@(posedge clk) disable iff (!rst_n)
        ((WRITE_BACK != 0) && mem_ack && mem_we) |=> (mem_req && !mem_we));

    // R9: in write-through mode, every memory write is the pending store itself
    a_r9_store_forward: assert property (@(posedge clk) disable iff (!rst_n)
        ((WRITE_BACK == 0) && mem_req && mem_we) |->
            (cpu_req && cpu_we && (mem_addr == cpu_addr) && (mem_wdata == cpu_wdata)));

endmodule

bind cache_assoc cache_assoc_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WRITE_BACK(WRITE_BACK)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_req   (cpu_req),
    .cpu_we    (cpu_we),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .cpu_ready (cpu_ready),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack)
);

// File: tb/tb_cache_assoc.sv
// Backing memory model: acknowledges each request after a fixed wait.
module tb_mem_model #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mem_req,
    input  logic              mem_we,
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_wdata,
    output logic              mem_ack,
    output logic [DATA_W-1:0] mem_rdata,
    output int                n_reads,
    output int                n_writes,
    output logic [ADDR_W-1:0] last_waddr,
    output logic [DATA_W-1:0] last_wdata
);
    logic [DATA_W-1:0] arr [2**ADDR_W];
    int                cnt;

    initial begin
        for (int i = 0; i < 2**ADDR_W; i++) arr[i] = DATA_W'({i[7:0], ~i[7:0]});
    end

    // Transfer timing: ack pulses two waiting cycles after the request.
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0; cnt <= 0; n_reads <= 0; n_writes <= 0;
            last_waddr <= '0; last_wdata <= '0; mem_rdata <= '0;
        end else if (mem_ack) begin
            mem_ack <= 1'b0; cnt <= 0;
        end else if (mem_req) begin
            if (cnt == 2) begin
                mem_ack <= 1'b1;
                if (mem_we) begin
                    arr[mem_addr] <= mem_wdata; n_writes <= n_writes + 1;
                    last_waddr <= mem_addr; last_wdata <= mem_wdata;
                end else begin
                    mem_rdata <= arr[mem_addr]; n_reads <= n_reads + 1;
                end
            end else cnt <= cnt + 1;
        end
    end
endmodule

// Bench: three organizations of the cache against independent memory models.
module tb_cache_assoc;
    localparam int AW = 8;
    localparam int DW = 16;
    localparam int LAT_HIT = 1;   // accept edge + response cycle
    localparam int LAT_ONE = 5;   // one memory transfer
    localparam int LAT_TWO = 9;   // two memory transfers

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;  // 125 MHz

    logic          c_req [3];
    logic          c_we [3];
    logic [AW-1:0] c_addr [3];
    logic [DW-1:0] c_wdata [3];
    logic          c_ready [3];
    logic [DW-1:0] c_rdata [3];
    logic          m_req [3];
    logic          m_we [3];
    logic [AW-1:0] m_addr [3];
    logic [DW-1:0] m_wdata [3];
    logic          m_ack [3];
    logic [DW-1:0] m_rdata [3];
    int            m_rd [3];
    int            m_wr [3];
    logic [AW-1:0] m_lwa [3];
    logic [DW-1:0] m_lwd [3];

    int n_checks = 0;
    int n_errors = 0;
    int hold_bad = 0;
    bit finished = 0;

    // dut: 4 sets x 4 ways, write-back
    cache_assoc #(.ADDR_W(AW), .DATA_W(DW), .NUM_SETS(4), .NUM_WAYS(4), .WRITE_BACK(1)) dut (
        .clk(clk), .rst_n(rst_n), .cpu_req(c_req[0]), .cpu_we(c_we[0]), .cpu_addr(c_addr[0]),
        .cpu_wdata(c_wdata[0]), .cpu_ready(c_ready[0]), .cpu_rdata(c_rdata[0]),
        .mem_req(m_req[0]), .mem_we(m_we[0]), .mem_addr(m_addr[0]), .mem_wdata(m_wdata[0]),
        .mem_ack(m_ack[0]), .mem_rdata(m_rdata[0]));
    // dut_dm: 4 sets x 1 way, write-through
    cache_assoc #(.ADDR_W(AW), .DATA_W(DW), .NUM_SETS(4), .NUM_WAYS(1), .WRITE_BACK(0)) dut_dm (
        .clk(clk), .rst_n(rst_n), .cpu_req(c_req[1]), .cpu_we(c_we[1]), .cpu_addr(c_addr[1]),
        .cpu_wdata(c_wdata[1]), .cpu_ready(c_ready[1]), .cpu_rdata(c_rdata[1]),
        .mem_req(m_req[1]), .mem_we(m_we[1]), .mem_addr(m_addr[1]), .mem_wdata(m_wdata[1]),
        .mem_ack(m_ack[1]), .mem_rdata(m_rdata[1]));
    // dut_fa: 1 set x 4 ways, write-back
    cache_assoc #(.ADDR_W(AW), .DATA_W(DW), .NUM_SETS(1), .NUM_WAYS(4), .WRITE_BACK(1)) dut_fa (
        .clk(clk), .rst_n(rst_n), .cpu_req(c_req[2]), .cpu_we(c_we[2]), .cpu_addr(c_addr[2]),
        .cpu_wdata(c_wdata[2]), .cpu_ready(c_ready[2]), .cpu_rdata(c_rdata[2]),
        .mem_req(m_req[2]), .mem_we(m_we[2]), .mem_addr(m_addr[2]), .mem_wdata(m_wdata[2]),
        .mem_ack(m_ack[2]), .mem_rdata(m_rdata[2]));

    generate
        for (genvar d = 0; d < 3; d++) begin : g_mem
            tb_mem_model #(.ADDR_W(AW), .DATA_W(DW)) u_mem (
                .clk(clk), .rst_n(rst_n), .mem_req(m_req[d]), .mem_we(m_we[d]),
                .mem_addr(m_addr[d]), .mem_wdata(m_wdata[d]), .mem_ack(m_ack[d]),
                .mem_rdata(m_rdata[d]), .n_reads(m_rd[d]), .n_writes(m_wr[d]),
                .last_waddr(m_lwa[d]), .last_wdata(m_lwd[d]));
        end
    endgenerate

    function automatic logic [DW-1:0] init_val(input int a);
        return DW'({a[7:0], ~a[7:0]});
    endfunction

    function automatic logic [DW-1:0] peek(input int d, input int a);
        case (d)
            0:       return g_mem[0].u_mem.arr[a];
            1:       return g_mem[1].u_mem.arr[a];
            default: return g_mem[2].u_mem.arr[a];
        endcase
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // One processor access; returns data and cycles from request to ready.
    task automatic access(input int d, input bit w, input int a, input logic [DW-1:0] wd,
                          output logic [DW-1:0] rd, output int lat);
        bit            p_req = 0;
        bit            p_ack = 0;
        logic [AW-1:0] p_addr = '0;
        @(negedge clk);
        c_req[d] = 1'b1; c_we[d] = w; c_addr[d] = AW'(a); c_wdata[d] = wd;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
            if (p_req && !p_ack && (!m_req[d] || m_addr[d] != p_addr)) hold_bad++;
            p_req = m_req[d]; p_ack = m_ack[d]; p_addr = m_addr[d];
        end while (!c_ready[d] && lat < 100);
        rd = c_rdata[d];
        c_req[d] = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [DW-1:0] rd;
        int lat, w0, r0;
        for (int d = 0; d < 3; d++) begin
            c_req[d] = 0; c_we[d] = 0; c_addr[d] = '0; c_wdata[d] = '0;
        end
        repeat (4) @(negedge clk);
        // R2: reset state of all three instances
        for (int d = 0; d < 3; d++) begin
            check("R2", "ready during reset", int'(c_ready[d]), 0);
            check("R2", "mem_req during reset", int'(m_req[d]), 0);
        end
        rst_n = 1'b1;
        @(negedge clk);
        for (int d = 0; d < 3; d++) check("R2", "mem_req after reset", int'(m_req[d]), 0);

        // ---- dut: 4x4 write-back ----
        // R2 R4 R5: every first read misses, fills free ways, evicts nothing
        for (int a = 0; a < 16; a++) begin
            access(0, 0, a, '0, rd, lat);
            check("R4", $sformatf("miss data a=%0d", a), int'(rd), int'(init_val(a)));
            check("R2", $sformatf("cold miss latency a=%0d", a), lat, LAT_ONE);
            check("R4", "one memory read per miss", m_rd[0], a + 1);
        end
        check("R5", "no eviction while ways free", m_wr[0], 0);
        // R1 R3: 0x0,0x4,0x8,0xC share set 0 and all still hit
        for (int a = 0; a < 16; a++) begin
            access(0, 0, a, '0, rd, lat);
            check("R1", $sformatf("resident hit latency a=%0d", a), lat, LAT_HIT);
            check("R3", $sformatf("hit data a=%0d", a), int'(rd), int'(init_val(a)));
        end
        check("R3", "hits make no memory read", m_rd[0], 16);
        // R10: store hits stay in the cache
        for (int a = 0; a < 16; a++) begin
            access(0, 1, a, DW'(16'hC000 + a), rd, lat);
            check("R10", $sformatf("store hit latency a=%0d", a), lat, LAT_HIT);
            check("R10", $sformatf("memory untouched a=%0d", a), int'(peek(0, a)), int'(init_val(a)));
        end
        check("R10", "no memory writes for store hits", m_wr[0], 0);
        // R6 R11: new addresses evict dirty lines in fill order
        for (int a = 16; a < 32; a++) begin
            access(0, 0, a, '0, rd, lat);
            check("R11", $sformatf("dirty miss latency a=%0d", a), lat, LAT_TWO);
            check("R6", $sformatf("victim address a=%0d", a), int'(m_lwa[0]), a - 16);
            check("R11", $sformatf("victim data a=%0d", a), int'(m_lwd[0]), 16'hC000 + a - 16);
            check("R4", $sformatf("refill data a=%0d", a), int'(rd), int'(init_val(a)));
        end
        // R11: written-back values survive; clean victims cause no write
        for (int a = 0; a < 16; a++) begin
            access(0, 0, a, '0, rd, lat);
            check("R11", $sformatf("reread data a=%0d", a), int'(rd), 16'hC000 + a);
            check("R6", $sformatf("clean victim latency a=%0d", a), lat, LAT_ONE);
        end
        check("R11", "write count after clean evictions", m_wr[0], 16);

        // ---- dut_dm: direct-mapped write-through ----
        access(1, 0, 0, '0, rd, lat);
        check("R7", "first read of 0 misses", lat, LAT_ONE);
        access(1, 0, 4, '0, rd, lat);
        check("R7", "read of 4 misses", lat, LAT_ONE);
        access(1, 0, 0, '0, rd, lat);
        check("R7", "0 evicted by 4", lat, LAT_ONE);
        check("R7", "0 refill data", int'(rd), int'(init_val(0)));
        access(1, 0, 0, '0, rd, lat);
        check("R3", "0 now hits", lat, LAT_HIT);
        // R9 R12: stores go to memory; misses allocate
        for (int a = 0; a < 4; a++) begin
            r0 = m_rd[1];
            access(1, 1, a, DW'(16'hD000 + a), rd, lat);
            check("R9", $sformatf("store latency a=%0d", a), lat, (a == 0) ? LAT_ONE : LAT_TWO);
            check("R9", $sformatf("memory updated a=%0d", a), int'(peek(1, a)), 16'hD000 + a);
            check("R12", $sformatf("write miss refill a=%0d", a), m_rd[1] - r0, (a == 0) ? 0 : 1);
        end
        check("R9", "write-through write count", m_wr[1], 4);
        for (int a = 0; a < 4; a++) begin
            access(1, 0, a, '0, rd, lat);
            check("R12", $sformatf("allocated line hits a=%0d", a), lat, LAT_HIT);
            check("R9", $sformatf("cache updated a=%0d", a), int'(rd), 16'hD000 + a);
        end
        for (int a = 4; a < 8; a++) begin
            access(1, 0, a, '0, rd, lat);
            check("R12", $sformatf("clean eviction latency a=%0d", a), lat, LAT_ONE);
        end
        check("R12", "no write for clean eviction", m_wr[1], 4);

        // ---- dut_fa: fully associative write-back ----
        for (int k = 0; k < 4; k++) begin
            access(2, 1, k * 35, DW'(16'hE000 + k), rd, lat);
            check("R12", $sformatf("write miss allocate k=%0d", k), lat, LAT_ONE);
        end
        check("R12", "write-allocate refill reads", m_rd[2], 4);
        check("R10", "dirty lines not written", m_wr[2], 0);
        for (int k = 0; k < 4; k++) begin
            access(2, 0, k * 35, '0, rd, lat);
            check("R8", $sformatf("all resident k=%0d", k), lat, LAT_HIT);
            check("R8", $sformatf("resident data k=%0d", k), int'(rd), 16'hE000 + k);
        end
        w0 = m_wr[2];
        access(2, 0, 128, '0, rd, lat);
        check("R6", "fifth address evicts first fill", int'(m_lwa[2]), 0);
        check("R11", "fully-assoc dirty eviction latency", lat, LAT_TWO);
        check("R11", "one writeback", m_wr[2] - w0, 1);
        access(2, 0, 0, '0, rd, lat);
        check("R11", "evicted value read back", int'(rd), 16'hE000);
        check("R6", "second victim is second fill", int'(m_lwa[2]), 35);
        access(2, 0, 128, '0, rd, lat);
        check("R8", "new line still resident", lat, LAT_HIT);

        check("R13", "memory request held until ack", hold_bad, 0);
        finish_run();
    end
endmodule